// File: doc/BRIEF.md
# Reference Frequency Divider

This block turns a reference oscillator clock into a single-cycle comparison pulse for a phase detector. The division ratio is programmable, and a select input picks one of two dividing paths. The prescaled path puts a fixed divide-by-8 stage in front of a 13-bit programmable counter, so the ratio is eight times the programmed count. The direct path uses the full 15-bit count with no pre-stage. The prescaled path is the default after reset.

The count and the select are sampled only at a terminal count. A new setting therefore never cuts the period that is running, and the phase detector sees clean comparison edges while software retunes the loop. Counts below five are raised to five. A standby input holds both counters at their reset values and forces the pulse low. When standby is released, the block restarts exactly as it does after reset.

Top module: `ref_divider`

## Requirements
- R1: While reset is asserted the pulse output is low. Reset starts the block in prescaled mode with a zero count, so whatever the select and count inputs are, the first pulse appears on the 8th rising clock edge after reset is released.
- R2: With the select latched at 0 (prescaled mode), pulses are 8×C clock cycles apart. C is `count_in[12:0]`, and `count_in[14:13]` has no effect.
- R3: With the select latched at 1 (direct mode), pulses are C clock cycles apart, where C is `count_in[14:0]`.
- R4: In either mode, a count below 5 (including 0) behaves as a count of 5. The period is then 40 cycles in prescaled mode and 5 cycles in direct mode.
- R5: The largest counts give periods of 65528 cycles in prescaled mode (count 8191) and 32767 cycles in direct mode (count 32767).
- R6: Each pulse is high for exactly one clock cycle.
- R7: The count and select are sampled at the clock edge that issues a pulse, and they set the length of the following period. A change made during a period does not alter that period. This applies to mode changes as well.
- R8: While standby is high, the pulse stays low and both counters are held cleared. After standby falls, the first pulse appears on the 8th rising edge, as it does after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | High holds the divider cleared and the pulse low |
| sel_direct | input | 1 | 0: fixed /8 plus 13-bit count; 1: 15-bit count only |
| count_in | input | 15 | Latched programmed count |
| ref_pulse | output | 1 | Single-cycle comparison pulse |

## Verification
Two events can fall on the same edge: a terminal count reloading the counter, and a new count or mode arriving from the latch. The bench changes the inputs right after it observes a pulse, and again a few cycles into a period. It then times the interval between pulses in clock cycles. The period that is running must keep its old length, and the period after it must take the new count and mode. A second collision is standby against a running count: the bench raises standby mid-period, requires the output to stay quiet, and requires the restart to follow the reset timing.

// File: rtl/refdiv_pkg.sv
// Package: shared types for the reference divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package refdiv_pkg;

    // Dividing path selected for the running period.
    typedef enum logic {
        MODE_PRESCALED = 1'b0,
        MODE_DIRECT    = 1'b1
    } refdiv_mode_e;

endpackage

// File: rtl/refdiv_prescaler.sv
// Module: free-running binary prescaler for the /2^PRE_W pre-stage.
// Assumes: clear is synchronous and dominates counting; the parent
// derives the tick from the all-ones state of pre_cnt.
module refdiv_prescaler #(
    parameter int unsigned PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [PRE_W-1:0] pre_cnt
);

    // Count up every clock, wrap naturally, hold at zero when cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/refdiv_load_sel.sv
// Module: forms the reload value and next mode from the latched inputs.
// Assumes: NARROW_W <= CNT_W; MIN_CNT fits in NARROW_W bits.
// Purely combinational; the period counter samples it at terminal count.
module refdiv_load_sel
    import refdiv_pkg::*;
#(
    parameter int unsigned CNT_W    = 15,
    parameter int unsigned NARROW_W = 13,
    parameter int unsigned MIN_CNT  = 5
) (
    input  logic [CNT_W-1:0] count_in,
    input  logic             sel_direct,
    output logic [CNT_W-1:0] load_val,
    output refdiv_mode_e     mode_next
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

    logic [CNT_W-1:0] narrow_val;
    logic [CNT_W-1:0] raw_val;

    // Narrow path keeps only the low NARROW_W bits of the count.
    generate
        if (NARROW_W < CNT_W) begin : g_zero_ext
            assign narrow_val = {{(CNT_W-NARROW_W){1'b0}}, count_in[NARROW_W-1:0]};
        end else begin : g_full
            assign narrow_val = count_in;
        end
    endgenerate

    // Choose the count for the requested path and apply the minimum.
    always_comb begin
        raw_val   = sel_direct ? count_in : narrow_val;
        load_val  = (raw_val < FLOOR) ? FLOOR : raw_val;
        mode_next = sel_direct ? MODE_DIRECT : MODE_PRESCALED;
    end

endmodule

// File: rtl/refdiv_period_counter.sv
// Module: programmable down-counter that sets the comparison period.
// Assumes: terminal = tick && cnt_q == 0, computed by the parent;
// load_val >= 1. A reload also latches the mode for the next period.
module refdiv_period_counter
    import refdiv_pkg::*;
#(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             terminal,
    input  logic [CNT_W-1:0] load_val,
    input  refdiv_mode_e     mode_next,
    output logic [CNT_W-1:0] cnt_q,
    output refdiv_mode_e     mode_q
);

    // Reload on terminal count, otherwise step down once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            mode_q <= MODE_PRESCALED;
        end else if (terminal) begin
            cnt_q  <= load_val - 1'b1;
            mode_q <= mode_next;
        end else if (tick) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/ref_divider.sv
// Module: reference frequency divider, top level.
// Divides clk by 8*C (prescaled path) or C (direct path) and issues one
// single-cycle pulse per period. Inputs are sampled only at terminal count.
// Assumes: count_in and sel_direct are already synchronous to clk.
module ref_divider
    import refdiv_pkg::*;
#(
    parameter int unsigned CNT_W    = 15,
    parameter int unsigned NARROW_W = 13,
    parameter int unsigned PRE_W    = 3,
    parameter int unsigned MIN_CNT  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             sel_direct,
    input  logic [CNT_W-1:0] count_in,
    output logic             ref_pulse
);

    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    refdiv_mode_e     mode_next;
    refdiv_mode_e     mode_q;
    logic             pre_clear;
    logic             pre_tick;
    logic             tick;
    logic             terminal;

    // Prescaler idles in direct mode and during standby.
    assign pre_clear = standby || (mode_q == MODE_DIRECT);
    assign pre_tick  = &pre_cnt;
    assign tick      = (mode_q == MODE_DIRECT) ? 1'b1 : pre_tick;
    assign terminal  = tick && (cnt_q == '0);

    refdiv_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pre_clear),
        .pre_cnt (pre_cnt)
    );

    refdiv_load_sel #(
        .CNT_W    (CNT_W),
        .NARROW_W (NARROW_W),
        .MIN_CNT  (MIN_CNT)
    ) u_load (
        .count_in   (count_in),
        .sel_direct (sel_direct),
        .load_val   (load_val),
        .mode_next  (mode_next)
    );

    refdiv_period_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (standby),
        .tick      (tick),
        .terminal  (terminal),
        .load_val  (load_val),
        .mode_next (mode_next),
        .cnt_q     (cnt_q),
        .mode_q    (mode_q)
    );

    // Register the terminal event as the one-cycle output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            ref_pulse <= 1'b0;
        end else begin
            ref_pulse <= terminal;
        end
    end

endmodule

// File: rtl/refdiv_checker.sv
// Module: assertion checker for ref_divider, attached by bind.
// Assumes: it sees the top-level ports and the internal counter state.
module refdiv_checker #(
    parameter int unsigned CNT_W   = 15,
    parameter int unsigned PRE_W   = 3,
    parameter int unsigned MIN_CNT = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             standby,
    input logic             ref_pulse,
    input logic             mode_q,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [CNT_W-1:0] cnt_q
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse); // R6

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse ##1 !ref_pulse ##1 !ref_pulse ##1 !ref_pulse); // R4

    AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n || standby)
        ref_pulse |-> (cnt_q >= CNT_W'(MIN_CNT - 1))); // R4

    AST_DIRECT_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (pre_cnt == '0)); // R3

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!ref_pulse && cnt_q == '0 && pre_cnt == '0 && !mode_q)); // R8

endmodule

bind ref_divider refdiv_checker #(
    .CNT_W   (CNT_W),
    .PRE_W   (PRE_W),
    .MIN_CNT (MIN_CNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .ref_pulse (ref_pulse),
    .mode_q    (mode_q),
    .pre_cnt   (pre_cnt),
    .cnt_q     (cnt_q)
);

// File: tb/tb_ref_divider.sv
`timescale 1ns/1ps
module tb_ref_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        sel_direct = 1'b0;
    logic [14:0] count_in = 15'd5;
    logic        ref_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ref_divider dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .sel_direct (sel_direct),
        .count_in   (count_in),
        .ref_pulse  (ref_pulse)
    );

    // Vector: {sel_direct, count_in, expected period in cycles}
    localparam int NV = 10;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 15'd5,     17'd5},      // R3 direct minimum
        {1'b1, 15'd0,     17'd5},      // R4 zero clamps
        {1'b1, 15'd3,     17'd5},      // R4 below floor clamps
        {1'b0, 15'd5,     17'd40},     // R2 prescaled minimum
        {1'b0, 15'd4,     17'd40},     // R4 prescaled clamp
        {1'b0, 15'h6005,  17'd40},     // R2 upper bits ignored
        {1'b0, 15'd10,    17'd80},     // R2 prescaled x8
        {1'b1, 15'd100,   17'd100},    // R3 direct count
        {1'b1, 15'd32767, 17'd32767},  // R5 direct maximum
        {1'b0, 15'd8191,  17'd65528}   // R5 prescaled maximum
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until the pulse is seen high.
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ref_pulse);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        int bad;
        repeat (3) @(negedge clk);
        check(ref_pulse == 1'b0, "R1 reset low", int'(ref_pulse), 0);
        rst_n = 1'b1;
        wait_pulse(n);

        // Table walk: set inputs, let the running period end, time the next.
        for (int i = 0; i < NV; i++) begin
            sel_direct = VEC[i][32];
            count_in   = VEC[i][31:17];
            wait_pulse(n);
            wait_pulse(n);
            check(n == int'(VEC[i][16:0]), $sformatf("R2/R3/R4/R5 vec%0d", i), n, int'(VEC[i][16:0]));
        end

        // R1: first pulse on the 8th edge after reset even with direct selected.
        @(negedge clk);
        rst_n = 1'b0;
        sel_direct = 1'b1;
        count_in = 15'd5;
        repeat (2) @(negedge clk);
        check(ref_pulse == 1'b0, "R1 reset low", int'(ref_pulse), 0);
        rst_n = 1'b1;
        wait_pulse(n);
        check(n == 8, "R1 first pulse", n, 8);

        // R6: one cycle high.
        @(negedge clk);
        check(ref_pulse == 1'b0, "R6 width", int'(ref_pulse), 0);
        wait_pulse(n);
        check(n == 4, "R6 gap after pulse", n, 4);

        // R7: change just after a pulse; running period keeps its length.
        count_in = 15'd20;
        wait_pulse(n);
        check(n == 5, "R7 old period kept", n, 5);
        wait_pulse(n);
        check(n == 20, "R7 new count", n, 20);
        repeat (3) @(negedge clk);
        count_in = 15'd50;
        sel_direct = 1'b0;
        wait_pulse(n);
        check(n + 3 == 20, "R7 mid-period change", n + 3, 20);
        wait_pulse(n);
        check(n == 400, "R7 mode switch", n, 400);

        // R8: standby mid-period holds output low, restart follows reset timing.
        repeat (30) @(negedge clk);
        standby = 1'b1;
        bad = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (ref_pulse) bad++;
        end
        check(bad == 0, "R8 standby quiet", bad, 0);
        sel_direct = 1'b1;
        count_in = 15'd5;
        standby = 1'b0;
        wait_pulse(n);
        check(n == 8, "R8 restart", n, 8);
        wait_pulse(n);
        check(n == 5, "R8 direct after restart", n, 5);

        finish_run();
    end

endmodule